// File: doc/BRIEF.md
# Calendar Date Counter

This block holds a calendar date (day, month, year) in registers and moves it forward by one day on each single-cycle advance pulse. Month lengths follow the Gregorian calendar, including the full leap-year rule for centuries. At the end of December the date wraps to January and the year counts up. A combinational output gives the length of the month currently held.

A set mode lets a user or controller enter a date. While set mode is high, a load strobe writes day, month and year in one cycle. Advance pulses in set mode move the day forward without regard to the month's length, so any day from 1 to 31 can be reached. A day that would reach 32 is still folded back to 1 with a month advance. When set mode is dropped with a day beyond the month's end, the next normal advance corrects the date by starting the following month.

All control pins are plain level or strobe inputs sampled on the rising clock edge. There is no streamed data and so no back-pressure: the block accepts an advance or load on every cycle.

Top module: `cal_date_counter`

## Requirements
- R1: A synchronous active-high reset sets day 1, month 1 and year RESET_YEAR (2000 by default). Reset wins over a load and over an advance in the same cycle.
- R2: The month-length output is 30 for months 4, 6, 9 and 11. It is 31 for months 1, 3, 5, 7, 8, 10 and 12. Months are coded 1 to 12 in binary.
- R3: For month 2 the month-length output is 29 when the year is a leap year and 28 otherwise. A year is a leap year when it divides by 400, or when it divides by 4 but not by 100.
- R4: With set mode low, an advance on a day below the month length adds one to the day and leaves month and year unchanged.
- R5: With set mode low, an advance on a day at or above the month length sets the day to 1 and adds one to the month.
- R6: A month rollover from month 12 sets the month to 1 and adds one to the year. The year is a YEAR_W-bit binary value that wraps modulo 2^YEAR_W.
- R7: With set mode high, an advance on a day below 31 adds one to the day whatever the month length, and leaves the month unchanged.
- R8: An advance on day 31 sets the day to 1 and advances the month in either mode. The held day never exceeds 31.
- R9: When set mode and the load strobe are both high, the next state is the supplied day, month and year. This holds even if an advance pulse arrives in the same cycle.
- R10: A load strobe while set mode is low is ignored. An advance in the same cycle acts as if no load were present.
- R11: With no reset, no advance and no accepted load, the date holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| day_adv | input | 1 | One-cycle pulse: move forward one day |
| set_mode | input | 1 | High while the date is being entered |
| load_en | input | 1 | Load strobe, accepted only in set mode |
| load_day | input | 5 | Day value to load |
| load_mon | input | 4 | Month value to load (1 to 12) |
| load_year | input | YEAR_W (12) | Year value to load |
| day_o | output | 5 | Current day |
| mon_o | output | 4 | Current month |
| year_o | output | YEAR_W (12) | Current year |
| mon_days_o | output | 5 | Number of days in the current month |

## Verification
The bench targets four corner cases.

- The leap decision at the century years 1900, 2100 and 2000, 2400, and in an exhaustive pass over all 4096 year codes. A design using only the divide-by-4 test would report 29 days for February 1900.
- Month-end rollover across complete years. An off-by-one comparison would either skip the last day of each month or produce day 29, 30 or 31 where none exists.
- Set-mode advances past the month length up to 31. A design that kept the length check active in set mode would roll over early. A design that dropped the 32 guard would show day 0 or a day above 31.
- Load priority and the December wrap, including the wrap of year 4095 to 0. A design that let an advance win over a load, or that took loads outside set mode, would show a date other than the one entered.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int MON_W    = 4;
  localparam int DAY_W    = 6;   // five day bits plus one headroom bit
  localparam int DAY_CAP  = 31;
  localparam int MON_LAST = 12;

  typedef logic [MON_W-1:0] mon_t;
  typedef logic [DAY_W-1:0] day_t;
  typedef logic [DAY_W-2:0] dlen_t;

  localparam mon_t M_FEB = 4'd2;
  localparam mon_t M_APR = 4'd4;
  localparam mon_t M_JUN = 4'd6;
  localparam mon_t M_SEP = 4'd9;
  localparam mon_t M_NOV = 4'd11;

  typedef enum logic [1:0] {
    LEN_LONG,
    LEN_SHORT,
    LEN_FEB_LEAP,
    LEN_FEB_PLAIN
  } len_cls_e;
endpackage

// File: rtl/cal_leap.sv
module cal_leap #(
  parameter int YEAR_W = 12
) (
  input  logic [YEAR_W-1:0] year,
  output logic              leap
);
  localparam logic [YEAR_W-1:0] FIVE_SQ = YEAR_W'(25);

  logic by4, by16, by25;

  // 400 = 16 * 25 and 100 = 4 * 25, so one non-power-of-two residue suffices
  assign by4  = (year[1:0] == 2'b00);
  assign by16 = (year[3:0] == 4'h0);
  assign by25 = ((year % FIVE_SQ) == '0);
  assign leap = by4 && (by16 || !by25);
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
  import cal_pkg::*;
(
  input  mon_t  mon,
  input  logic  leap,
  output dlen_t dim
);
  len_cls_e cls;
  logic     short_mon;

  always_comb begin
    case (mon)
      M_APR, M_JUN, M_SEP, M_NOV: short_mon = 1'b1;
      default:                    short_mon = 1'b0;
    endcase
  end

  // priority: 30-day months, leap February, plain February, everything else
  always_comb begin
    if (short_mon)                 cls = LEN_SHORT;
    else if (mon == M_FEB && leap) cls = LEN_FEB_LEAP;
    else if (mon == M_FEB)         cls = LEN_FEB_PLAIN;
    else                           cls = LEN_LONG;
  end

  always_comb begin
    case (cls)
      LEN_SHORT:     dim = dlen_t'(30);
      LEN_FEB_LEAP:  dim = dlen_t'(29);
      LEN_FEB_PLAIN: dim = dlen_t'(28);
      default:       dim = dlen_t'(31);
    endcase
  end
endmodule

// File: rtl/cal_step.sv
module cal_step
  import cal_pkg::*;
#(
  parameter int YEAR_W = 12
) (
  input  day_t              day,
  input  mon_t              mon,
  input  logic [YEAR_W-1:0] year,
  input  dlen_t             dim,
  input  logic              free_run,
  output day_t              day_n,
  output mon_t              mon_n,
  output logic [YEAR_W-1:0] year_n
);
  day_t inc;
  logic past_cap, month_end, year_end;

  always_comb begin
    inc       = day + day_t'(1);
    past_cap  = (inc > day_t'(DAY_CAP));
    month_end = past_cap || (!free_run && (day >= {1'b0, dim}));
    year_end  = month_end && (mon >= mon_t'(MON_LAST));

    day_n  = month_end ? day_t'(1) : inc;
    if (!month_end)    mon_n = mon;
    else if (year_end) mon_n = mon_t'(1);
    else               mon_n = mon + mon_t'(1);
    year_n = year_end ? (year + YEAR_W'(1)) : year;
  end
endmodule

// File: rtl/cal_date_counter.sv
module cal_date_counter
  import cal_pkg::*;
#(
  parameter int YEAR_W     = 12,
  parameter int RESET_YEAR = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              day_adv,
  input  logic              set_mode,
  input  logic              load_en,
  input  logic [4:0]        load_day,
  input  logic [3:0]        load_mon,
  input  logic [YEAR_W-1:0] load_year,
  output logic [4:0]        day_o,
  output logic [3:0]        mon_o,
  output logic [YEAR_W-1:0] year_o,
  output logic [4:0]        mon_days_o
);
  day_t              day_q, day_nx;
  mon_t              mon_q, mon_nx;
  logic [YEAR_W-1:0] year_q, year_nx;
  logic              leap;
  dlen_t             dim;
  logic              take_load;

  cal_leap #(.YEAR_W(YEAR_W)) u_leap (
    .year (year_q),
    .leap (leap)
  );

  cal_month_len u_len (
    .mon  (mon_q),
    .leap (leap),
    .dim  (dim)
  );

  cal_step #(.YEAR_W(YEAR_W)) u_step (
    .day      (day_q),
    .mon      (mon_q),
    .year     (year_q),
    .dim      (dim),
    .free_run (set_mode),
    .day_n    (day_nx),
    .mon_n    (mon_nx),
    .year_n   (year_nx)
  );

  assign take_load = set_mode && load_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      day_q  <= day_t'(1);
      mon_q  <= mon_t'(1);
      year_q <= YEAR_W'(RESET_YEAR);
    end else if (take_load) begin
      day_q  <= {1'b0, load_day};
      mon_q  <= load_mon;
      year_q <= load_year;
    end else if (day_adv) begin
      day_q  <= day_nx;
      mon_q  <= mon_nx;
      year_q <= year_nx;
    end
  end

  assign day_o      = day_q[DAY_W-2:0];
  assign mon_o      = mon_q;
  assign year_o     = year_q;
  assign mon_days_o = dim;
endmodule

// File: rtl/cal_date_counter_chk.sv
module cal_date_counter_chk #(
  parameter int YEAR_W     = 12,
  parameter int RESET_YEAR = 2000
) (
  input logic              clk,
  input logic              rst,
  input logic              day_adv,
  input logic              set_mode,
  input logic              load_en,
  input logic [4:0]        load_day,
  input logic [3:0]        load_mon,
  input logic [YEAR_W-1:0] load_year,
  input logic [5:0]        day_q,
  input logic [3:0]        mon_o,
  input logic [YEAR_W-1:0] year_o,
  input logic [4:0]        mon_days_o
);
  logic rst_seen = 1'b0;
  always_ff @(posedge clk) rst_seen <= rst;

  always_ff @(posedge clk) begin
    if (rst_seen)
      AST_RESET_VAL: assert (day_q == 6'd1 && mon_o == 4'd1 && year_o == YEAR_W'(RESET_YEAR)) else $error("reset value"); // R1
  end

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (mon_days_o >= 5'd28) && (mon_days_o <= 5'd31)) else $error("month length range"); // R2

  AST_NORMAL_STEP: assert property (@(posedge clk) disable iff (rst)
    (day_adv && !set_mode && day_q < {1'b0, mon_days_o})
    |=> (day_q == $past(day_q) + 6'd1) && $stable(mon_o) && $stable(year_o)) else $error("normal step"); // R4

  AST_MONTH_ROLL: assert property (@(posedge clk) disable iff (rst)
    (day_adv && !set_mode && day_q >= {1'b0, mon_days_o} && mon_o < 4'd12)
    |=> (day_q == 6'd1) && (mon_o == $past(mon_o) + 4'd1) && $stable(year_o)) else $error("month roll"); // R5

  AST_YEAR_ROLL: assert property (@(posedge clk) disable iff (rst)
    (day_adv && !set_mode && day_q >= {1'b0, mon_days_o} && mon_o >= 4'd12)
    |=> (day_q == 6'd1) && (mon_o == 4'd1) && (year_o == $past(year_o) + YEAR_W'(1))) else $error("year roll"); // R6

  AST_SET_FREE: assert property (@(posedge clk) disable iff (rst)
    (day_adv && set_mode && !load_en && day_q < 6'd31)
    |=> (day_q == $past(day_q) + 6'd1) && $stable(mon_o)) else $error("set-mode step"); // R7

  AST_DAY_CAP: assert property (@(posedge clk) disable iff (rst)
    day_q <= 6'd31) else $error("day above 31"); // R8

  AST_LOAD_TAKE: assert property (@(posedge clk) disable iff (rst)
    (set_mode && load_en)
    |=> (day_q == {1'b0, $past(load_day)}) && (mon_o == $past(load_mon)) && (year_o == $past(load_year))) else $error("load"); // R9

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!day_adv && !(set_mode && load_en))
    |=> $stable(day_q) && $stable(mon_o) && $stable(year_o)) else $error("hold"); // R11
endmodule

bind cal_date_counter cal_date_counter_chk #(
  .YEAR_W     (YEAR_W),
  .RESET_YEAR (RESET_YEAR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .day_adv    (day_adv),
  .set_mode   (set_mode),
  .load_en    (load_en),
  .load_day   (load_day),
  .load_mon   (load_mon),
  .load_year  (load_year),
  .day_q      (day_q),
  .mon_o      (mon_o),
  .year_o     (year_o),
  .mon_days_o (mon_days_o)
);

// File: tb/sim_cal_date_counter.sv
`timescale 1ns/1ps
module sim_cal_date_counter;
  logic        clk = 1'b0;
  logic        rst, day_adv, set_mode, load_en;
  logic [4:0]  load_day;
  logic [3:0]  load_mon;
  logic [11:0] load_year;
  logic [4:0]  day_o, mon_days_o;
  logic [3:0]  mon_o;
  logic [11:0] year_o;

  int total = 0;
  int bad   = 0;
  int ed, em, ey;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  cal_date_counter u0 (
    .clk(clk), .rst(rst), .day_adv(day_adv), .set_mode(set_mode), .load_en(load_en),
    .load_day(load_day), .load_mon(load_mon), .load_year(load_year),
    .day_o(day_o), .mon_o(mon_o), .year_o(year_o), .mon_days_o(mon_days_o)
  );

  function automatic int bdim(int m, int y);
    bit lp;
    lp = (y % 400 == 0) || ((y % 4 == 0) && (y % 100 != 0));
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    if (m == 2) return lp ? 29 : 28;
    return 31;
  endfunction

  // advance the bench model; returns the tag of the rule used
  function automatic string model_adv(bit free);
    bit roll;
    roll = (ed + 1 > 31) || (!free && ed >= bdim(em, ey));
    if (!roll) begin
      ed = ed + 1;
      return free ? "R7" : "R4";
    end
    ed = 1;
    if (em >= 12) begin
      em = 1;
      ey = (ey + 1) % 4096;
      return "R6";
    end
    em = em + 1;
    return free ? "R8" : "R5";
  endfunction

  task automatic chk(string tag);
    total++;
    if (day_o !== 5'(ed) || mon_o !== 4'(em) || year_o !== 12'(ey)) begin
      bad++;
      $display("FAIL %s: got %0d/%0d/%0d expected %0d/%0d/%0d",
               tag, day_o, mon_o, year_o, ed, em, ey);
    end
  endtask

  task automatic chk_len(string tag, int exp);
    total++;
    if (mon_days_o !== 5'(exp)) begin
      bad++;
      $display("FAIL %s: month length got %0d expected %0d (month %0d year %0d)",
               tag, mon_days_o, exp, mon_o, year_o);
    end
  endtask

  task automatic cyc(bit a, bit s, bit l, int d, int m, int y);
    day_adv = a; set_mode = s; load_en = l;
    load_day = 5'(d); load_mon = 4'(m); load_year = 12'(y);
    @(posedge clk);
    @(negedge clk);
    day_adv = 1'b0; load_en = 1'b0;
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    string tag;
    int years[8] = '{1900, 1999, 2000, 2023, 2024, 2100, 2400, 4095};
    rst = 1'b1; day_adv = 1'b1; set_mode = 1'b1; load_en = 1'b1;
    load_day = 5'd9; load_mon = 4'd9; load_year = 12'd9;
    @(negedge clk);
    repeat (2) begin @(posedge clk); @(negedge clk); end
    ed = 1; em = 1; ey = 2000;
    chk("R1 reset beats load and advance");
    rst = 1'b0; day_adv = 1'b0; load_en = 1'b0; set_mode = 1'b0;
    chk_len("R2 January", 31);

    for (int i = 0; i < 5; i++) begin
      cyc(0, 0, 0, 0, 0, 0);
      chk("R11 hold");
    end
    cyc(0, 1, 0, 4, 4, 4);
    chk("R11 set mode without strobe");

    cyc(1, 1, 1, 15, 7, 1999);
    ed = 15; em = 7; ey = 1999;
    chk("R9 load beats advance");

    cyc(1, 0, 1, 3, 3, 3);
    void'(model_adv(0));
    chk("R10 load ignored outside set mode");

    // full-year sweeps in normal mode
    foreach (years[k]) begin
      cyc(0, 1, 1, 1, 1, years[k]);
      ed = 1; em = 1; ey = years[k];
      chk("R9 load year start");
      for (int n = 0; n < 370; n++) begin
        cyc(1, 0, 0, 0, 0, 0);
        tag = model_adv(0);
        chk(tag);
        chk_len((em == 2) ? "R3" : "R2", bdim(em, ey));
      end
    end

    // set-mode advances past month length
    for (int m = 1; m <= 12; m++) begin
      cyc(0, 1, 1, 25, m, 2023);
      ed = 25; em = m; ey = 2023;
      for (int n = 0; n < 8; n++) begin
        cyc(1, 1, 0, 0, 0, 0);
        tag = model_adv(1);
        chk(tag);
      end
    end

    // leaving set mode with a day past month end
    cyc(0, 1, 1, 30, 2, 2023);
    ed = 30; em = 2; ey = 2023;
    chk("R7 impossible day accepted in set mode");
    cyc(1, 0, 0, 0, 0, 0);
    ed = 1; em = 3;
    chk("R5 overlong day corrected");

    // exhaustive leap decision
    for (int y = 0; y < 4096; y++) begin
      cyc(0, 1, 1, 1, 2, y);
      chk_len("R3 February", bdim(2, y));
    end
    for (int m = 1; m <= 12; m++) begin
      cyc(0, 1, 1, 1, m, 2001);
      chk_len("R2 month table", bdim(m, 2001));
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule